// File: doc/BRIEF.md
# Two-Plane Cursor Overlay

This block lays a 64x64 hardware cursor over a stream of 24-bit RGB pixels. For each pixel clock it receives the beam position and the incoming pixel. One clock later it outputs either that pixel unchanged or one of two programmable cursor colours. The cursor image uses two bits per pixel. The upper bit of each pair marks the pixel as visible or transparent, and the lower bit picks the colour.

Software reaches all state through a byte-wide host port with four locations: the low byte of a 16-bit index, the high byte of that index, an index control byte and a data byte. Reads and writes of the data byte go to the internal register that the index selects. When auto-increment is on, software can stream the 1024-byte image in one burst of writes. The cursor origin is computed as position minus hotspot minus one. With a hotspot of 63, software writes each screen coordinate plus 64, which lets the cursor slide off the top and left edges.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, pixOut is 0, the index and index control read 0, and every internal register reads 0, so the cursor is hidden.
- R2: hostPort selects the location: 0 is index bits 7:0, 1 is index bits 15:8, 2 is index control, 3 is data. A write is taken on a clock edge with hostWr high. hostRdata shows the selected location combinationally.
- R3: When index control bit 0 is 1, every data write advances the 16-bit index by one, wrapping from 0xFFFF to 0x0000. When that bit is 0, the index is unchanged. Reads never move the index.
- R4: The internal map is as follows. 0x0000 is mode. 0x0001 and 0x0002 are X position low and high. 0x0003 and 0x0004 are Y position low and high; each high register keeps only bits 3:0 and reads its upper nibble as 0. 0x0005 is hotspot X and 0x0006 is hotspot Y. 0x0010 to 0x0012 hold colour 0 as R, G, B. 0x0013 to 0x0015 hold colour 1 as R, G, B. 0x0400 to 0x07FF hold the image bytes, and these can be read back.
- R5: An index outside that map reads 0, and a write to it changes nothing.
- R6: Cursor pixel (cx, cy) is stored in byte 0x0400 + 16*cy + cx/4. Pixel cx mod 4 = 0 uses bits 7:6, 1 uses bits 5:4, 2 uses bits 3:2 and 3 uses bits 1:0. In each pair the upper bit 1 means visible and 0 means transparent; the lower bit selects colour 1 when set and colour 0 when clear.
- R7: Cursor pixel (cx, cy) covers beam position (posX - hotX - 1 + cx, posY - hotY - 1 + cy). Any part of the cursor that would fall at a negative coordinate is not drawn, and positions do not wrap.
- R8: The cursor is drawn only while mode bits 1:0 are nonzero. The other mode bits are stored and read back, but they have no effect.
- R9: pixOut changes one clock after beamX, beamY and pixIn are applied. It carries the selected colour for a visible cursor pixel; otherwise it carries the delayed pixIn.
- R10: A colour is output as {R, G, B}, with R in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostPort | input | 2 | Host location select |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for the selected location |
| beamX | input | 12 | Current beam column |
| beamY | input | 12 | Current beam row |
| pixIn | input | 24 | Incoming RGB pixel |
| pixOut | output | 24 | Pixel with overlay, one clock late |

## Verification
The image is filled with an address-dependent pattern that uses all four pair codes. Windows just larger than the cursor are then scanned, so every edge row and column is compared with pixels just outside it. The scans use four setups:
- hotspot 63 with position offset by 64, which tests the origin arithmetic;
- hotspot 0, which exposes any off-by-one in that arithmetic;
- an origin at negative coordinates, which catches wrap-around;
- mode 0x24 against mode 0x01, which shows that only bits 1:0 gate the overlay.

The incoming pixel carries its own coordinates, so a one-clock misalignment shows as a value mismatch. Streamed writes, repeated writes at a fixed index, index wrap, unmapped indices and the masked high nibbles are all checked by reading back through the data port.

// File: rtl/curov_pkg.sv
package curov_pkg;
  localparam int CUR_DIM      = 64;
  localparam int COORD_W      = 12;
  localparam int CHAN_W       = 8;
  localparam int PIX_W        = 3 * CHAN_W;
  localparam int IDX_W        = 16;
  localparam int HOT_W        = 8;
  localparam int BPP          = 2;
  localparam int PIX_PER_BYTE = 8 / BPP;
  localparam int LINE_BYTES   = CUR_DIM / PIX_PER_BYTE;
  localparam int BMP_BYTES    = CUR_DIM * LINE_BYTES;
  localparam int BMP_AW       = $clog2(BMP_BYTES);
  localparam int COL_BYTES    = 2 * 3;

  localparam logic [1:0] PORT_IDX_LO  = 2'd0;
  localparam logic [1:0] PORT_IDX_HI  = 2'd1;
  localparam logic [1:0] PORT_IDX_CTL = 2'd2;
  localparam logic [1:0] PORT_DATA    = 2'd3;

  localparam logic [IDX_W-1:0] IX_MODE     = 16'h0000;
  localparam logic [IDX_W-1:0] IX_XLO      = 16'h0001;
  localparam logic [IDX_W-1:0] IX_XHI      = 16'h0002;
  localparam logic [IDX_W-1:0] IX_YLO      = 16'h0003;
  localparam logic [IDX_W-1:0] IX_YHI      = 16'h0004;
  localparam logic [IDX_W-1:0] IX_HOTX     = 16'h0005;
  localparam logic [IDX_W-1:0] IX_HOTY     = 16'h0006;
  localparam logic [IDX_W-1:0] IX_COL_BASE = 16'h0010;
  // image occupies one aligned page of the index space: 0x0400..0x07FF
  localparam logic [IDX_W-BMP_AW-1:0] BMP_PAGE = 1;

  typedef struct packed {
    logic              bmWrEn;
    logic [BMP_AW-1:0] bmAddr;
    logic [7:0]        bmWrData;
  } bmStrobe_t;

  typedef struct packed {
    logic               curOn;
    logic [COORD_W-1:0] posX;
    logic [COORD_W-1:0] posY;
    logic [HOT_W-1:0]   hotX;
    logic [HOT_W-1:0]   hotY;
    logic [PIX_W-1:0]   col0;
    logic [PIX_W-1:0]   col1;
  } curCfg_t;
endpackage

// File: rtl/curov_ctrl.sv
module curov_ctrl
  import curov_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostPort,
  input  logic       hostWr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic [7:0] bmRdData,
  output bmStrobe_t  bmStb,
  output curCfg_t    cfg
);
  logic [IDX_W-1:0]   idxQ;
  logic [7:0]         idxCtlQ;
  logic [7:0]         modeQ;
  logic [COORD_W-1:0] posXQ, posYQ;
  logic [HOT_W-1:0]   hotXQ, hotYQ;
  logic [CHAN_W-1:0]  colQ [COL_BYTES];
  logic               dataWr, bmHit, implHit;
  logic [7:0]         regVal;
  logic               primed;

  assign dataWr = hostWr && (hostPort == PORT_DATA);
  assign bmHit  = (idxQ[IDX_W-1:BMP_AW] == BMP_PAGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ    <= '0;
      idxCtlQ <= '0;
      modeQ   <= '0;
      posXQ   <= '0;
      posYQ   <= '0;
      hotXQ   <= '0;
      hotYQ   <= '0;
      for (int k = 0; k < COL_BYTES; k++) colQ[k] <= '0;
    end else begin
      if (hostWr && hostPort == PORT_IDX_LO)  idxQ[7:0]       <= hostWdata;
      if (hostWr && hostPort == PORT_IDX_HI)  idxQ[IDX_W-1:8] <= hostWdata;
      if (hostWr && hostPort == PORT_IDX_CTL) idxCtlQ         <= hostWdata;
      if (dataWr) begin
        case (idxQ)
          IX_MODE: modeQ                <= hostWdata;
          IX_XLO:  posXQ[7:0]           <= hostWdata;
          IX_XHI:  posXQ[COORD_W-1:8]   <= hostWdata[COORD_W-9:0];
          IX_YLO:  posYQ[7:0]           <= hostWdata;
          IX_YHI:  posYQ[COORD_W-1:8]   <= hostWdata[COORD_W-9:0];
          IX_HOTX: hotXQ                <= hostWdata;
          IX_HOTY: hotYQ                <= hostWdata;
          default: ;
        endcase
        for (int k = 0; k < COL_BYTES; k++)
          if (idxQ == IX_COL_BASE + IDX_W'(k)) colQ[k] <= hostWdata;
        if (idxCtlQ[0]) idxQ <= idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    implHit = 1'b1;
    regVal  = '0;
    case (idxQ)
      IX_MODE: regVal = modeQ;
      IX_XLO:  regVal = posXQ[7:0];
      IX_XHI:  regVal = 8'(posXQ[COORD_W-1:8]);
      IX_YLO:  regVal = posYQ[7:0];
      IX_YHI:  regVal = 8'(posYQ[COORD_W-1:8]);
      IX_HOTX: regVal = hotXQ;
      IX_HOTY: regVal = hotYQ;
      default: implHit = 1'b0;
    endcase
    for (int k = 0; k < COL_BYTES; k++) begin
      if (idxQ == IX_COL_BASE + IDX_W'(k)) begin
        regVal  = colQ[k];
        implHit = 1'b1;
      end
    end
    if (bmHit) begin
      regVal  = bmRdData;
      implHit = 1'b1;
    end
  end

  always_comb begin
    case (hostPort)
      PORT_IDX_LO:  hostRdata = idxQ[7:0];
      PORT_IDX_HI:  hostRdata = idxQ[IDX_W-1:8];
      PORT_IDX_CTL: hostRdata = idxCtlQ;
      default:      hostRdata = regVal;
    endcase
  end

  assign bmStb.bmWrEn   = dataWr && bmHit;
  assign bmStb.bmAddr   = idxQ[BMP_AW-1:0];
  assign bmStb.bmWrData = hostWdata;

  assign cfg.curOn = |modeQ[1:0];
  assign cfg.posX  = posXQ;
  assign cfg.posY  = posYQ;
  assign cfg.hotX  = hotXQ;
  assign cfg.hotY  = hotYQ;
  assign cfg.col0  = {colQ[0], colQ[1], colQ[2]};
  assign cfg.col1  = {colQ[3], colQ[4], colQ[5]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R3: streaming writes advance the index by one
  p_autoinc_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(dataWr && idxCtlQ[0]) |-> idxQ == $past(idxQ) + 1'b1);

  // R3: with auto-increment off, a data write leaves the index alone
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(dataWr && !idxCtlQ[0]) |-> $stable(idxQ));

  // R5: unmapped indices read as zero
  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostPort == PORT_DATA && !implHit) |-> hostRdata == 8'h00);

  // R4: high position registers expose only their low nibble
  p_hi_nibble_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostPort == PORT_DATA && (idxQ == IX_XHI || idxQ == IX_YHI)) |-> hostRdata[7:4] == 4'h0);
endmodule

// File: rtl/curov_datapath.sv
module curov_datapath
  import curov_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bmStrobe_t          bmStb,
  output logic [7:0]         bmRdData,
  input  curCfg_t            cfg,
  input  logic [COORD_W-1:0] beamX,
  input  logic [COORD_W-1:0] beamY,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut
);
  localparam int DW    = COORD_W + 2;
  localparam int DIM_W = $clog2(CUR_DIM);

  logic [7:0]         bmp [BMP_BYTES];
  logic [COORD_W-1:0] beamAx [2];
  logic [COORD_W-1:0] posAx  [2];
  logic [HOT_W-1:0]   hotAx  [2];
  logic [DIM_W-1:0]   offAx  [2];
  logic               inAx   [2];
  logic [7:0]         rowByte;
  logic [1:0]         pairBits;
  logic               inWin, showPix, primed;

  always_ff @(posedge clk) begin
    if (bmStb.bmWrEn) bmp[bmStb.bmAddr] <= bmStb.bmWrData;
  end
  assign bmRdData = bmp[bmStb.bmAddr];

  assign beamAx[0] = beamX;
  assign beamAx[1] = beamY;
  assign posAx[0]  = cfg.posX;
  assign posAx[1]  = cfg.posY;
  assign hotAx[0]  = cfg.hotX;
  assign hotAx[1]  = cfg.hotY;

  // offset of the beam from the cursor origin, one per axis
  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    logic [DW-1:0] delta;
    assign delta     = DW'(beamAx[ax]) + DW'(hotAx[ax]) + DW'(1) - DW'(posAx[ax]);
    assign inAx[ax]  = (delta[DW-1:DIM_W] == '0);
    assign offAx[ax] = delta[DIM_W-1:0];
  end

  assign rowByte = bmp[{offAx[1], offAx[0][DIM_W-1:2]}];

  always_comb begin
    case (offAx[0][1:0])
      2'd0:    pairBits = rowByte[7:6];
      2'd1:    pairBits = rowByte[5:4];
      2'd2:    pairBits = rowByte[3:2];
      default: pairBits = rowByte[1:0];
    endcase
  end

  assign inWin   = inAx[0] && inAx[1];
  assign showPix = cfg.curOn && inWin && pairBits[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pixOut <= '0;
    else if (showPix) pixOut <= pairBits[0] ? cfg.col1 : cfg.col0;
    else              pixOut <= pixIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R8: a disabled cursor passes the pixel through
  p_hidden_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    primed && !$past(cfg.curOn) |-> pixOut == $past(pixIn));

  // R7: outside the cursor window the pixel is untouched
  p_outside_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && !$past(inWin) |-> pixOut == $past(pixIn));

  // R10: an overlaid pixel is one of the two programmed colours
  p_colour_r10: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(showPix) |-> (pixOut == $past(cfg.col0) || pixOut == $past(cfg.col1)));

  // R9: the output holds for one clock only when the inputs repeat
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(!showPix) && $past(pixIn) != $past(pixIn, 2) && $past(primed) |-> !$stable(pixOut) || pixOut == $past(pixIn));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import curov_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         hostPort,
  input  logic               hostWr,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  input  logic [COORD_W-1:0] beamX,
  input  logic [COORD_W-1:0] beamY,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut
);
  bmStrobe_t  bmStb;
  curCfg_t    cfg;
  logic [7:0] bmRdData;

  curov_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostPort  (hostPort),
    .hostWr    (hostWr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .bmRdData  (bmRdData),
    .bmStb     (bmStb),
    .cfg       (cfg)
  );

  curov_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bmStb    (bmStb),
    .bmRdData (bmRdData),
    .cfg      (cfg),
    .beamX    (beamX),
    .beamY    (beamY),
    .pixIn    (pixIn),
    .pixOut   (pixOut)
  );
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  hostPort;
  logic        hostWr;
  logic [7:0]  hostWdata;
  logic [7:0]  hostRdata;
  logic [11:0] beamX, beamY;
  logic [23:0] pixIn, pixOut;

  always #2 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rstN(rstN), .hostPort(hostPort), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .beamX(beamX),
    .beamY(beamY), .pixIn(pixIn), .pixOut(pixOut)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural model state
  int idx, ictl, mode, px, py, hx, hy;
  int col [6];
  int bm [1024];
  logic [23:0] expPix;
  bit expValid = 0;

  localparam int IDLE_X = 4095;
  localparam int IDLE_Y = 4095;
  localparam logic [23:0] IDLE_PIX = 24'h5A5A5A;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] modelPix(int bx, int by, logic [23:0] pix);
    int cx, cy, b, pr;
    cx = bx + hx + 1 - px;
    cy = by + hy + 1 - py;
    if ((mode & 3) == 0 || cx < 0 || cx > 63 || cy < 0 || cy > 63) return pix;
    b  = bm[cy * 16 + cx / 4];
    pr = (b >> (6 - 2 * (cx % 4))) & 3;
    if ((pr & 2) == 0) return pix;
    if ((pr & 1) != 0) return {col[3][7:0], col[4][7:0], col[5][7:0]};
    return {col[0][7:0], col[1][7:0], col[2][7:0]};
  endfunction

  function automatic int modelData(int i);
    if (i == 0) return mode;
    if (i == 1) return px & 255;
    if (i == 2) return (px >> 8) & 15;
    if (i == 3) return py & 255;
    if (i == 4) return (py >> 8) & 15;
    if (i == 5) return hx;
    if (i == 6) return hy;
    if (i >= 16 && i < 22) return col[i - 16];
    if (i >= 1024 && i < 2048) return bm[i - 1024];
    return 0;
  endfunction

  function automatic void modelWrite(int port, int d);
    int i;
    case (port)
      0: idx = (idx & 'hFF00) | d;
      1: idx = (idx & 'h00FF) | (d << 8);
      2: ictl = d;
      default: begin
        i = idx;
        if (i == 0) mode = d;
        else if (i == 1) px = (px & 'hF00) | d;
        else if (i == 2) px = (px & 'hFF) | ((d & 15) << 8);
        else if (i == 3) py = (py & 'hF00) | d;
        else if (i == 4) py = (py & 'hFF) | ((d & 15) << 8);
        else if (i == 5) hx = d;
        else if (i == 6) hy = d;
        else if (i >= 16 && i < 22) col[i - 16] = d;
        else if (i >= 1024 && i < 2048) bm[i - 1024] = d;
        if ((ictl & 1) != 0) idx = (idx + 1) & 'hFFFF;
      end
    endcase
  endfunction

  function automatic int modelPort(int port);
    case (port)
      0: return idx & 255;
      1: return (idx >> 8) & 255;
      2: return ictl;
      default: return modelData(idx);
    endcase
  endfunction

  // one clock: compare the previous expectation, apply new inputs
  task automatic tick(input bit wr, input int port, input int d, input int bx, input int by, input logic [23:0] pix);
    @(negedge clk);
    if (expValid) chk(pixOut == expPix, "R9 pixel (R6/R7/R10)", 32'(pixOut), 32'(expPix));
    hostWr    = wr;
    hostPort  = 2'(port);
    hostWdata = 8'(d);
    beamX     = 12'(bx);
    beamY     = 12'(by);
    pixIn     = pix;
    expPix    = modelPix(bx, by, pix);
    expValid  = 1;
    if (wr) modelWrite(port, d);
  endtask

  task automatic wreg(input int port, input int d);
    tick(1, port, d, IDLE_X, IDLE_Y, IDLE_PIX);
  endtask

  task automatic setIdx(input int v);
    wreg(0, v & 255);
    wreg(1, (v >> 8) & 255);
  endtask

  task automatic wIdx(input int v, input int d);
    setIdx(v);
    wreg(3, d);
  endtask

  task automatic readChk(input int port, input int exp, input string tag);
    tick(0, port, 0, IDLE_X, IDLE_Y, IDLE_PIX);
    #1;
    chk(hostRdata == 8'(exp), tag, 32'(hostRdata), 32'(exp));
    chk(hostRdata == 8'(modelPort(port)), "R2 model readback", 32'(hostRdata), 32'(modelPort(port)));
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        tick(0, 0, 0, x, y, {8'(x), 8'(y), 8'(x ^ (y << 2))});
  endtask

  task automatic placeCursor(input int hotX, input int hotY, input int posX, input int posY);
    wIdx(5, hotX);
    wIdx(6, hotY);
    wIdx(1, posX & 255);
    wIdx(2, posX >> 8);
    wIdx(3, posY & 255);
    wIdx(4, posY >> 8);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idx = 0; ictl = 0; mode = 0; px = 0; py = 0; hx = 0; hy = 0;
    for (int k = 0; k < 6; k++) col[k] = 0;
    for (int k = 0; k < 1024; k++) bm[k] = 0;
    rstN = 0; hostWr = 0; hostPort = 0; hostWdata = 0;
    beamX = 0; beamY = 0; pixIn = 24'hFFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(pixOut == 24'h0, "R1 pixOut in reset", 32'(pixOut), 0);
    for (int p = 0; p < 3; p++) begin
      hostPort = 2'(p);
      #1;
      chk(hostRdata == 8'h00, "R1 index location in reset", 32'(hostRdata), 0);
    end
    rstN = 1;
    readChk(3, 0, "R1 mode after reset");
    scan(0, 3, 0, 1); // R8: hidden after reset, pass-through

    // R3: streamed image load
    wreg(2, 1);
    setIdx('h0400);
    for (int i = 0; i < 1024; i++)
      wreg(3, (i * 29 + (i >> 4) * 7 + 3) & 255);
    readChk(0, 'h00, "R3 index low after 1024 writes");
    readChk(1, 'h08, "R3 index high after 1024 writes");
    // R3: read does not advance
    setIdx('h0405);
    readChk(3, (5 * 29 + 3) & 255, "R4 image byte readback");
    readChk(0, 'h05, "R3 index unchanged by read");
    setIdx('h07FF);
    readChk(3, (1023 * 29 + 63 * 7 + 3) & 255, "R4 last image byte");

    // R3: fixed index writes, colours through it
    wreg(2, 0);
    wIdx('h0010, 'h11);
    wreg(3, 'hC0);
    readChk(0, 'h10, "R3 index held with increment off");
    readChk(3, 'hC0, "R3 repeated write at fixed index");
    wIdx('h0011, 'h40); wIdx('h0012, 'h0F);
    wIdx('h0013, 'h1E); wIdx('h0014, 'hE3); wIdx('h0015, 'h77);
    setIdx('h0014);
    readChk(3, 'hE3, "R4 colour 1 green");

    // R5: unmapped indices
    wIdx('h0007, 'hAB);
    readChk(3, 0, "R5 unmapped read");
    wIdx('h0800, 'h5C);
    readChk(3, 0, "R5 past image end");
    wIdx('h03FF, 'h99);
    readChk(3, 0, "R5 before image start");
    setIdx('h0400);
    readChk(3, 3, "R5 image start untouched");

    // R4: high position nibble
    wIdx('h0002, 'hF5);
    readChk(3, 'h05, "R4 X high keeps low nibble");
    wIdx('h0004, 'hA3);
    readChk(3, 'h03, "R4 Y high keeps low nibble");

    // R7: hotspot 63, position = coord + 64
    placeCursor(63, 63, 100 + 64, 50 + 64);
    wIdx(0, 'h27);
    readChk(3, 'h27, "R8 mode readback");
    scan(98, 165, 48, 115);

    // R8: bits 1:0 clear hides, other bits kept
    wIdx(0, 'h24);
    readChk(3, 'h24, "R8 upper mode bits kept");
    scan(96, 170, 60, 70);

    // R7: hotspot 0, mode with bit 0 only
    wIdx(0, 'h01);
    placeCursor(0, 0, 10, 5);
    scan(0, 79, 0, 74);

    // R7: origin at negative coordinates, no wrap
    placeCursor(63, 63, 20, 10);
    scan(0, 31, 0, 15);
    scan(4060, 4095, 4085, 4095);

    // R3: index wraps
    wreg(2, 1);
    setIdx('hFFFF);
    wreg(3, 'h12);
    readChk(0, 0, "R3 index wrap low");
    readChk(1, 0, "R3 index wrap high");

    @(negedge clk);
    chk(pixOut == expPix, "R9 final pixel", 32'(pixOut), 32'(expPix));
    summary();
    $finish;
  end
endmodule